// File: doc/BRIEF.md
# Two-Way Page Translation Cache

This block keeps recently used page translations for 4 KiB pages close to the pipeline. It has two independent arrays: instruction fetches use one, and every other access uses the other. Each array has a parameterised number of sets, 64 by default. The set is picked directly by the low bits of the virtual page number. Each set holds two ways and one recency bit.

A lookup presents an effective address and an access kind. In the same cycle the block answers with one of three results:
- a plain hit, with the physical address;
- a changed-bit update, when a store touches a clean page;
- a miss.

An external page-table walker fills the block after misses. Software-driven invalidation clears the translations of a page. Lookups by debug probes can read the cache without disturbing the replacement order. Probe accesses also never mark pages dirty and never cause fills.

Top module: `xlat_cache`

## Requirements
- R1: The page tag is address bits 31:12. The set index is the low log2(SETS) bits of that tag, which is bits 17:12 at the default size. Two pages that share a set, such as tags 0x00012 and 0x00052, are held at the same time, one in each way.
- R2: Access kind codes:
  - 0: read.
  - 1: write.
  - 2: fetch.
  - 3: data probe.
  - 4: fetch probe.
  - 5 to 7: treated as data probes.
  
  Codes 2 and 4 use the instruction array and all other codes use the data array. A translation filled into one array is never seen by lookups of the other array.
- R3: On a hit, lk_paddr is the stored second page-table word's bits 31:12 joined with lookup address bits 11:0. lk_pte shows the stored word. Both are valid combinationally in the cycle of the request.
- R4: A write (code 1) that matches a way whose stored word has bit 7 clear does the following:
  - It gives lk_cupd=1 and lk_hit=0, with lk_paddr formed as in R3 and lk_pte showing the word before the update.
  - It sets bit 7 of the stored word at the clock edge.
  
  A repeat of the write then gives a plain hit.
- R5: A hit by a read, write or fetch sets the set's recency bit to the way that hit. A hit by a probe kind (codes 3 to 7) leaves the recency bit unchanged.
- R6: A fill writes way 1 when the recency bit is 0 and way 0 holds a valid tag; otherwise it writes way 0. The recency bit then takes the number of the way written. The fill stores the tag and the full 32-bit second page-table word.
- R7: A fill whose kind is a probe (codes 3 to 7) is dropped and leaves both arrays unchanged.
- R8: An invalidate marks both ways of the addressed set invalid in both arrays. After that, lookups of those pages miss.
- R9: Reset invalidates every entry, so every lookup after reset misses. The all-ones tag marks an invalid way, so page 0xFFFFF never hits, even after a fill.
- R10: While rf_valid or iv_valid is high, a lookup reports lk_hit=0, lk_cupd=0, lk_paddr=0 and lk_pte=0, and changes no stored state. An invalidate in the same cycle as a fill drops the fill.
- R11: Only write lookups produce lk_cupd. Read and probe hits on a page whose bit 7 is clear are plain hits and leave the bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_kind | input | 3 | Lookup access kind (R2 codes) |
| lk_addr | input | 32 | Lookup effective address |
| rf_valid | input | 1 | Fill command present |
| rf_kind | input | 3 | Access kind that caused the fill |
| rf_addr | input | 32 | Effective address of the page being filled |
| rf_pte | input | 32 | Second page-table word; bits 31:12 are the frame |
| iv_valid | input | 1 | Invalidate command present |
| iv_addr | input | 32 | Address whose set is invalidated |
| lk_hit | output | 1 | Plain hit |
| lk_cupd | output | 1 | Write hit that set the changed bit |
| lk_paddr | output | 32 | Physical address on hit or changed-bit update, else 0 |
| lk_pte | output | 32 | Stored second page-table word of the matching way, else 0 |

## Verification
Three pages that share one set are filled and looked up in orders that make the victim choice visible. Whether a page survives the next fill shows whether the recency bit followed the hit, stayed put under a probe, or was seeded correctly by a fill into an empty way. Writes to clean and dirty pages tell the changed-bit update apart from a plain hit. Reads and probes on clean pages show that only stores mark pages. Fills and lookups are crossed between the two arrays, and a fill of probe kind is tried, to show separation and refusal. Fills and invalidates arriving in the same cycle as lookups, or together with each other, confirm which command wins and that the blocked operation leaves no trace.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int TAG_W      = ADDR_W - PAGE_SHIFT;
    localparam int WAYS       = 2;
    localparam int C_BIT      = 7;

    typedef logic [TAG_W-1:0]  vpn_t;
    typedef logic [ADDR_W-1:0] word_t;

    localparam vpn_t TAG_NONE = '1;

    typedef enum logic [2:0] {
        ACC_READ   = 3'd0,
        ACC_WRITE  = 3'd1,
        ACC_FETCH  = 3'd2,
        ACC_PEEK_D = 3'd3,
        ACC_PEEK_I = 3'd4
    } acc_e;

    // Result of probing one array for one page
    typedef struct packed {
        logic  match;    // some way holds the page
        logic  way;      // way that matched (way 0 wins)
        logic  c_clear;  // write matched a clean page
        word_t pte;      // stored second page-table word
    } probe_t;

    function automatic vpn_t page_of(input word_t a);
        return a[ADDR_W-1:PAGE_SHIFT];
    endfunction

    function automatic logic kind_is_fetch(input logic [2:0] k);
        return (k == ACC_FETCH) || (k == ACC_PEEK_I);
    endfunction

    function automatic logic kind_is_peek(input logic [2:0] k);
        return !((k == ACC_READ) || (k == ACC_WRITE) || (k == ACC_FETCH));
    endfunction

    // Replacement: take way 1 only when recency points at 0 and way 0 is live
    function automatic logic pick_victim(input logic rec, input logic way0_live);
        return (!rec) && way0_live;
    endfunction

endpackage

// File: rtl/xlat_way_match.sv
module xlat_way_match
    import xlat_pkg::*;
(
    input  vpn_t [WAYS-1:0] way_tag,
    input  vpn_t            key,
    output logic [WAYS-1:0] hit
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w] = (way_tag[w] == key) && (way_tag[w] != TAG_NONE);
    end

endmodule

// File: rtl/xlat_side.sv
module xlat_side
    import xlat_pkg::*;
#(
    parameter int SETS = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  vpn_t  lk_vpn,
    input  logic  lk_write,
    input  logic  lk_peek,
    input  logic  lk_commit,
    input  logic  fill_en,
    input  vpn_t  fill_vpn,
    input  word_t fill_pte,
    input  logic  drop_en,
    input  logic [$clog2(SETS)-1:0] drop_idx,
    output probe_t res
);

    localparam int IDX_W = $clog2(SETS);
    typedef logic [IDX_W-1:0] idx_t;

    vpn_t  [WAYS-1:0] tag_q [SETS];
    word_t [WAYS-1:0] pte_q [SETS];
    logic  [SETS-1:0] rec_q;

    idx_t lk_idx;
    idx_t fill_idx;
    logic victim;
    vpn_t [WAYS-1:0] lk_tags;
    logic [WAYS-1:0] lk_hitv;

    assign lk_idx   = lk_vpn[IDX_W-1:0];
    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign lk_tags  = tag_q[lk_idx];
    assign victim   = pick_victim(rec_q[fill_idx], tag_q[fill_idx][0] != TAG_NONE);

    xlat_way_match u_match (
        .way_tag (lk_tags),
        .key     (lk_vpn),
        .hit     (lk_hitv)
    );

    always_comb begin
        res         = '0;
        res.match   = |lk_hitv;
        res.way     = !lk_hitv[0];
        res.pte     = res.match ? pte_q[lk_idx][res.way] : '0;
        res.c_clear = res.match && lk_write && !res.pte[C_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s] <= {WAYS{TAG_NONE}};
                pte_q[s] <= '0;
            end
            rec_q <= '0;
        end else if (drop_en) begin
            tag_q[drop_idx] <= {WAYS{TAG_NONE}};
        end else if (fill_en) begin
            tag_q[fill_idx][victim] <= fill_vpn;
            pte_q[fill_idx][victim] <= fill_pte;
            rec_q[fill_idx]         <= victim;
        end else if (lk_commit && res.match) begin
            if (res.c_clear) begin
                pte_q[lk_idx][res.way][C_BIT] <= 1'b1;
            end else if (!lk_peek) begin
                rec_q[lk_idx] <= res.way;
            end
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int SETS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_valid,
    input  logic [2:0]  lk_kind,
    input  logic [31:0] lk_addr,
    input  logic        rf_valid,
    input  logic [2:0]  rf_kind,
    input  logic [31:0] rf_addr,
    input  logic [31:0] rf_pte,
    input  logic        iv_valid,
    input  logic [31:0] iv_addr,
    output logic        lk_hit,
    output logic        lk_cupd,
    output logic [31:0] lk_paddr,
    output logic [31:0] lk_pte
);

    localparam int IDX_W = $clog2(SETS);
    localparam int NSIDE = 2;   // index 0: data array, 1: instruction array

    logic   act;
    logic   lk_side;
    logic   rf_side;
    logic   rf_ok;
    probe_t side_res [NSIDE];
    probe_t sel;
    logic [IDX_W-1:0] iv_idx;

    assign act     = lk_valid && !(rf_valid || iv_valid);
    assign lk_side = kind_is_fetch(lk_kind);
    assign rf_side = kind_is_fetch(rf_kind);
    assign rf_ok   = rf_valid && !iv_valid && !kind_is_peek(rf_kind);
    assign iv_idx  = iv_addr[PAGE_SHIFT +: IDX_W];

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        xlat_side #(.SETS(SETS)) u_side (
            .clk       (clk),
            .rst       (rst),
            .lk_vpn    (page_of(lk_addr)),
            .lk_write  (lk_kind == ACC_WRITE),
            .lk_peek   (kind_is_peek(lk_kind)),
            .lk_commit (act && (lk_side == s[0])),
            .fill_en   (rf_ok && (rf_side == s[0])),
            .fill_vpn  (page_of(rf_addr)),
            .fill_pte  (rf_pte),
            .drop_en   (iv_valid),
            .drop_idx  (iv_idx),
            .res       (side_res[s])
        );
    end

    assign sel      = lk_side ? side_res[1] : side_res[0];
    assign lk_hit   = act && sel.match && !sel.c_clear;
    assign lk_cupd  = act && sel.c_clear;
    assign lk_pte   = act ? sel.pte : '0;
    assign lk_paddr = (lk_hit || lk_cupd) ?
                      {sel.pte[ADDR_W-1:PAGE_SHIFT], lk_addr[PAGE_SHIFT-1:0]} : '0;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [2:0]  lk_kind,
    input logic [31:0] lk_addr,
    input logic        rf_valid,
    input logic        iv_valid,
    input logic [31:0] iv_addr,
    input logic        lk_hit,
    input logic        lk_cupd,
    input logic [31:0] lk_paddr,
    input logic [31:0] lk_pte
);

    AST_HIT_CUPD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_cupd)); // R4

    AST_CUPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        lk_cupd |=> !(lk_cupd && lk_addr[31:12] == $past(lk_addr[31:12]) && lk_kind == $past(lk_kind))); // R4

    AST_PADDR_FORM: assert property (@(posedge clk) disable iff (rst)
        (lk_hit || lk_cupd) |-> (lk_valid && lk_paddr[11:0] == lk_addr[11:0] && lk_paddr[31:12] == lk_pte[31:12])); // R3

    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rf_valid || iv_valid) |-> (!lk_hit && !lk_cupd && lk_paddr == 32'h0 && lk_pte == 32'h0)); // R10

    AST_CUPD_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        lk_cupd |-> (lk_kind == 3'd1)); // R11

    AST_DROP_MISS: assert property (@(posedge clk) disable iff (rst)
        iv_valid |=> !((lk_hit || lk_cupd) && lk_addr[31:12] == $past(iv_addr[31:12]))); // R8

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_hit && !lk_cupd)); // R9

    AST_TOP_PAGE_MISS: assert property (@(posedge clk) disable iff (rst)
        (lk_hit || lk_cupd) |-> (lk_addr[31:12] != 20'hFFFFF)); // R9

endmodule

bind xlat_cache xlat_cache_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_kind  (lk_kind),
    .lk_addr  (lk_addr),
    .rf_valid (rf_valid),
    .iv_valid (iv_valid),
    .iv_addr  (iv_addr),
    .lk_hit   (lk_hit),
    .lk_cupd  (lk_cupd),
    .lk_paddr (lk_paddr),
    .lk_pte   (lk_pte)
);

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;

    localparam logic [1:0] OP_LOOK = 2'd0;
    localparam logic [1:0] OP_FILL = 2'd1;
    localparam logic [1:0] OP_DROP = 2'd2;

    localparam logic [2:0] K_RD = 3'd0;
    localparam logic [2:0] K_WR = 3'd1;
    localparam logic [2:0] K_FE = 3'd2;
    localparam logic [2:0] K_PD = 3'd3;
    localparam logic [2:0] K_PI = 3'd4;
    localparam logic [2:0] K_X5 = 3'd5;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  kind;
        logic [31:0] addr;
        logic [31:0] pte;
        logic        eh;
        logic        ec;
        logic [31:0] ep;
        logic [31:0] et;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 29;

    // Pages A, B, C share set 0x12; page D sits in set 3
    localparam vec_t VECS [NV] = '{
        '{OP_LOOK, K_RD, 32'h00012345, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd9},  // R9 empty after reset
        '{OP_FILL, K_RD, 32'h00012000, 32'h12345000, 1'b0, 1'b0, 32'h0, 32'h0,        8'd6},  // R6 empty set -> way0
        '{OP_LOOK, K_RD, 32'h00012345, 32'h0, 1'b1, 1'b0, 32'h12345345, 32'h12345000, 8'd3},  // R3
        '{OP_LOOK, K_FE, 32'h00012345, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd2},  // R2 other array
        '{OP_FILL, K_WR, 32'h00052000, 32'h0ABCD080, 1'b0, 1'b0, 32'h0, 32'h0,        8'd6},  // R6 -> way1
        '{OP_LOOK, K_RD, 32'h00012345, 32'h0, 1'b1, 1'b0, 32'h12345345, 32'h12345000, 8'd1},  // R1 both present
        '{OP_LOOK, K_RD, 32'h00052000, 32'h0, 1'b1, 1'b0, 32'h0ABCD000, 32'h0ABCD080, 8'd1},  // R1
        '{OP_LOOK, K_PD, 32'h00012345, 32'h0, 1'b1, 1'b0, 32'h12345345, 32'h12345000, 8'd5},  // R5 probe hit
        '{OP_FILL, K_RD, 32'h00092000, 32'h07777000, 1'b0, 1'b0, 32'h0, 32'h0,        8'd6},  // R6 recency 1 -> way0
        '{OP_LOOK, K_RD, 32'h00012345, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd5},  // R5 probe kept recency
        '{OP_LOOK, K_RD, 32'h00052000, 32'h0, 1'b1, 1'b0, 32'h0ABCD000, 32'h0ABCD080, 8'd6},  // R6
        '{OP_LOOK, K_RD, 32'h000920AB, 32'h0, 1'b1, 1'b0, 32'h077770AB, 32'h07777000, 8'd11}, // R11 read clean page
        '{OP_FILL, K_RD, 32'h00012000, 32'h12345000, 1'b0, 1'b0, 32'h0, 32'h0,        8'd6},  // R6 -> way1
        '{OP_LOOK, K_RD, 32'h00052000, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd6},  // R6 B evicted
        '{OP_LOOK, K_WR, 32'h00012345, 32'h0, 1'b0, 1'b1, 32'h12345345, 32'h12345000, 8'd4},  // R4 update
        '{OP_LOOK, K_WR, 32'h00012345, 32'h0, 1'b1, 1'b0, 32'h12345345, 32'h12345080, 8'd4},  // R4 now dirty
        '{OP_LOOK, K_PD, 32'h00092000, 32'h0, 1'b1, 1'b0, 32'h07777000, 32'h07777000, 8'd11}, // R11 probe clean
        '{OP_FILL, K_PI, 32'h00003000, 32'h00400000, 1'b0, 1'b0, 32'h0, 32'h0,        8'd7},  // R7 probe fill
        '{OP_LOOK, K_FE, 32'h00003000, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd7},  // R7
        '{OP_FILL, K_FE, 32'h00003000, 32'h00400000, 1'b0, 1'b0, 32'h0, 32'h0,        8'd2},
        '{OP_LOOK, K_FE, 32'h00003010, 32'h0, 1'b1, 1'b0, 32'h00400010, 32'h00400000, 8'd2},  // R2
        '{OP_LOOK, K_RD, 32'h00003010, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd2},  // R2
        '{OP_LOOK, K_X5, 32'h00012FFF, 32'h0, 1'b1, 1'b0, 32'h12345FFF, 32'h12345080, 8'd2},  // R2 code 5 data
        '{OP_LOOK, K_PI, 32'h00003004, 32'h0, 1'b1, 1'b0, 32'h00400004, 32'h00400000, 8'd2},  // R2 code 4 fetch
        '{OP_DROP, K_RD, 32'h00012800, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8},
        '{OP_LOOK, K_RD, 32'h00092000, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8},  // R8
        '{OP_LOOK, K_RD, 32'h00012345, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8},  // R8
        '{OP_DROP, K_RD, 32'h00003000, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8},
        '{OP_LOOK, K_FE, 32'h00003000, 32'h0, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8}   // R8 fetch array
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [2:0]  lk_kind;
    logic [31:0] lk_addr;
    logic        rf_valid;
    logic [2:0]  rf_kind;
    logic [31:0] rf_addr;
    logic [31:0] rf_pte;
    logic        iv_valid;
    logic [31:0] iv_addr;
    logic        lk_hit;
    logic        lk_cupd;
    logic [31:0] lk_paddr;
    logic [31:0] lk_pte;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    xlat_cache dut (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .lk_kind  (lk_kind),
        .lk_addr  (lk_addr),
        .rf_valid (rf_valid),
        .rf_kind  (rf_kind),
        .rf_addr  (rf_addr),
        .rf_pte   (rf_pte),
        .iv_valid (iv_valid),
        .iv_addr  (iv_addr),
        .lk_hit   (lk_hit),
        .lk_cupd  (lk_cupd),
        .lk_paddr (lk_paddr),
        .lk_pte   (lk_pte)
    );

    task automatic idle();
        lk_valid = 1'b0; lk_kind = K_RD; lk_addr = '0;
        rf_valid = 1'b0; rf_kind = K_RD; rf_addr = '0; rf_pte = '0;
        iv_valid = 1'b0; iv_addr = '0;
    endtask

    task automatic put(input logic [1:0] op, input logic [2:0] kind,
                       input logic [31:0] addr, input logic [31:0] pte);
        idle();
        case (op)
            OP_LOOK: begin lk_valid = 1'b1; lk_kind = kind; lk_addr = addr; end
            OP_FILL: begin rf_valid = 1'b1; rf_kind = kind; rf_addr = addr; rf_pte = pte; end
            default: begin iv_valid = 1'b1; iv_addr = addr; end
        endcase
    endtask

    task automatic check(input string tag, input logic eh, input logic ec,
                         input logic [31:0] ep, input logic [31:0] et);
        checks++;
        if (lk_hit !== eh || lk_cupd !== ec || lk_paddr !== ep || lk_pte !== et) begin
            fails++;
            $display("FAIL %s: got hit=%0b cupd=%0b paddr=%h pte=%h, expected hit=%0b cupd=%0b paddr=%h pte=%h",
                     tag, lk_hit, lk_cupd, lk_paddr, lk_pte, eh, ec, ep, et);
        end
    endtask

    // Inputs change at the falling edge; outputs are sampled 1 ns later
    task automatic next();
        @(negedge clk);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 check("R9 reset idle", 1'b0, 1'b0, 32'h0, 32'h0);
        rst = 1'b0;
        next();

        for (int i = 0; i < NV; i++) begin
            put(VECS[i].op, VECS[i].kind, VECS[i].addr, VECS[i].pte);
            #1;
            if (VECS[i].op == OP_LOOK)
                check($sformatf("R%0d vector %0d", VECS[i].req, i),
                      VECS[i].eh, VECS[i].ec, VECS[i].ep, VECS[i].et);
            next();
        end

        // R10: a fill in the same cycle blocks the lookup, then takes effect
        put(OP_FILL, K_RD, 32'h00041000, 32'h00AAA000);
        next();
        put(OP_LOOK, K_RD, 32'h00041010, 32'h0);
        rf_valid = 1'b1; rf_kind = K_RD; rf_addr = 32'h00081000; rf_pte = 32'h00BBB000;
        #1 check("R10 lookup blocked by fill", 1'b0, 1'b0, 32'h0, 32'h0);
        next();
        put(OP_LOOK, K_RD, 32'h00081020, 32'h0);
        #1 check("R10 concurrent fill applied", 1'b1, 1'b0, 32'h00BBB020, 32'h00BBB000);
        next();
        put(OP_LOOK, K_RD, 32'h00041010, 32'h0);
        #1 check("R6 older page kept in way0", 1'b1, 1'b0, 32'h00AAA010, 32'h00AAA000);
        next();

        // R10: invalidate drops a fill in the same cycle
        put(OP_DROP, K_RD, 32'h00041000, 32'h0);
        rf_valid = 1'b1; rf_kind = K_RD; rf_addr = 32'h000C1000; rf_pte = 32'h00CCC000;
        next();
        put(OP_LOOK, K_RD, 32'h000C1000, 32'h0);
        #1 check("R10 fill dropped by invalidate", 1'b0, 1'b0, 32'h0, 32'h0);
        next();
        put(OP_LOOK, K_RD, 32'h00041000, 32'h0);
        #1 check("R8 set cleared", 1'b0, 1'b0, 32'h0, 32'h0);
        next();

        // R10: a blocked write must not set the changed bit
        put(OP_FILL, K_RD, 32'h00022000, 32'h00DDD000);
        next();
        put(OP_LOOK, K_WR, 32'h00022000, 32'h0);
        iv_valid = 1'b1; iv_addr = 32'h00005000;
        #1 check("R10 write blocked by invalidate", 1'b0, 1'b0, 32'h0, 32'h0);
        next();
        put(OP_LOOK, K_RD, 32'h00022000, 32'h0);
        #1 check("R10 changed bit untouched", 1'b1, 1'b0, 32'h00DDD000, 32'h00DDD000);
        next();

        // R9: the all-ones page never hits
        put(OP_FILL, K_RD, 32'hFFFFF000, 32'h00EEE000);
        next();
        put(OP_LOOK, K_RD, 32'hFFFFF123, 32'h0);
        #1 check("R9 top page never hits", 1'b0, 1'b0, 32'h0, 32'h0);
        next();

        // R9: reset in mid-run empties the arrays
        idle();
        rst = 1'b1;
        repeat (2) next();
        rst = 1'b0;
        put(OP_LOOK, K_RD, 32'h00022000, 32'h0);
        #1 check("R9 reset clears entries", 1'b0, 1'b0, 32'h0, 32'h0);
        next();
        idle();
        next();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule